// File: doc/BRIEF.md
# Daisy-Chained Converter Result Serializer

This block is the serial output sequencer inside one converter device. Up to eight identical devices form a chain that shares a single serial link to a host processor. All devices run on the same serial clock, share the same sample-period start strobe and hold the same configuration. Each device shifts its own 16-bit channel results toward the host. In the same stream it relays the words it receives from its upstream neighbour, so the host sees one interleaved stream: for every enabled channel, one word from each device, nearest device first.

A write port loads a chain-length field and a channel enable mask. The chain-length field holds the number of devices minus one. On each start strobe the block latches the local result buffer and walks the enabled channels in ascending order. Per channel it sends its own word and then as many relayed words as the chain-length field asks for. Every word slot is 17 serial clocks long: 16 data bits and one handoff clock, during which the line is low and the next word's frame sync follows.

Top module: `cas_out_seq`

## Requirements
- R1: The 3-bit chain-length field encodes value v as a chain of v+1 devices. Per enabled channel, each device sends exactly v+1 words: its own word and then v relayed words.
- R2: Channels are visited from index 0 upward, skipping disabled ones. Within a channel, the host receives the word of the device nearest to it first and the farthest device's word last.
- R3: A word is 16 bits, sent MSB first, one bit per clock. The output frame sync is high for exactly one clock, together with the MSB, and never during the other 15 bits.
- R4: Each word slot lasts 17 clocks. The clock after the 16th bit is a handoff clock with data low and frame sync low, so consecutive frame syncs within a sample period are exactly 17 clocks apart.
- R5: When a start strobe is sampled while idle with a non-empty mask, the first frame sync appears in the very next clock. After (v+1) × (enabled channel count) words the block returns to idle, with data and frame sync held low.
- R6: An upstream word is captured from the serial input, starting at the clock where the input frame sync is high. It is relayed in the slot that follows the slot in which it arrived.
- R7: A configuration write made while idle applies to the next sample period. A write made during a sample period, including one in the same clock as an accepted start strobe, is held and applies only after that sample period completes.
- R8: With an all-zero channel mask, a start strobe produces no frame sync and no data.
- R9: A start strobe that arrives while a sample period is in progress has no effect on the word stream.
- R10: After reset the chain-length field is 0, all channels are enabled, and data and frame sync outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Serial bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_count_i | input | 3 | Chain length minus one |
| cfg_mask_i | input | 6 | Channel enable mask, bit n enables channel n |
| frame_start_i | input | 1 | Sample-period start strobe |
| res_data_i | input | 96 | Local results, channel n in bits [16n+15:16n] |
| ser_d_i | input | 1 | Serial data from upstream device |
| ser_fs_i | input | 1 | Frame sync from upstream device |
| ser_d_o | output | 1 | Serial data toward host |
| ser_fs_o | output | 1 | Frame sync toward host |

## Verification
A slip in the bit counter moves the next frame sync off its 17-clock grid. The host end sees this within one slot. A wrong slot or channel pointer shows up in the next word compared, as a word from the wrong device or the wrong channel. A misaligned capture register corrupts the first relayed word, one slot after the upstream word arrived. Configuration that leaks into a running sample period changes the word count or order of that same period. A stale pending write shows in the following period.

// File: rtl/cas_seq_pkg.sv
`timescale 1ns/1ps
package cas_seq_pkg;
  localparam int unsigned CAS_CNT_W = 3;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } cas_state_e;
endpackage

// File: rtl/cas_pick.sv
`timescale 1ns/1ps
// lowest set request wins
module cas_pick #(
  parameter int unsigned N_CH = 6,
  localparam int unsigned IDX_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic [N_CH-1:0]  req_i,
  output logic             vld_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    vld_o = 1'b0;
    idx_o = '0;
    for (int i = N_CH - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        vld_o = 1'b1;
        idx_o = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/cas_cfg.sv
`timescale 1ns/1ps
// active config; writes during a frame are parked until done_i
module cas_cfg #(
  parameter int unsigned CNT_W = 3,
  parameter int unsigned N_CH  = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [N_CH-1:0]  mask_i,
  input  logic             busy_i,
  input  logic             done_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [N_CH-1:0]  mask_o
);
  logic [CNT_W-1:0] cnt_q, pend_cnt_q;
  logic [N_CH-1:0]  mask_q, pend_mask_q;
  logic             pend_vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q       <= '0;
      mask_q      <= '1;
      pend_cnt_q  <= '0;
      pend_mask_q <= '0;
      pend_vld_q  <= 1'b0;
    end else if (we_i && (!busy_i || done_i)) begin
      cnt_q      <= cnt_i;
      mask_q     <= mask_i;
      pend_vld_q <= 1'b0;
    end else if (done_i && pend_vld_q) begin
      cnt_q      <= pend_cnt_q;
      mask_q     <= pend_mask_q;
      pend_vld_q <= 1'b0;
    end else if (we_i) begin
      pend_cnt_q  <= cnt_i;
      pend_mask_q <= mask_i;
      pend_vld_q  <= 1'b1;
    end
  end

  assign cnt_o  = cnt_q;
  assign mask_o = mask_q;
endmodule

// File: rtl/cas_rx.sv
`timescale 1ns/1ps
// upstream word capture, qualified by the input frame sync
module cas_rx #(
  parameter int unsigned WORD_W = 16,
  localparam int unsigned CNT_W = $clog2(WORD_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sdi_i,
  input  logic              sfs_i,
  output logic [WORD_W-1:0] word_o
);
  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-1:0] sr_q, word_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sr_q   <= '0;
      word_q <= '0;
    end else begin
      if (sfs_i || cnt_q != '0) sr_q <= {sr_q[WORD_W-2:0], sdi_i};
      if (sfs_i) begin
        cnt_q <= CNT_W'(1);
      end else if (cnt_q == CNT_W'(WORD_W - 1)) begin
        cnt_q  <= '0;
        word_q <= {sr_q[WORD_W-2:0], sdi_i};
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  assign word_o = word_q;
endmodule

// File: rtl/cas_out_seq.sv
`timescale 1ns/1ps
module cas_out_seq
  import cas_seq_pkg::*;
#(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned N_CH   = 6,
  parameter int unsigned CNT_W  = CAS_CNT_W
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   cfg_we_i,
  input  logic [CNT_W-1:0]       cfg_count_i,
  input  logic [N_CH-1:0]        cfg_mask_i,
  input  logic                   frame_start_i,
  input  logic [N_CH*WORD_W-1:0] res_data_i,
  input  logic                   ser_d_i,
  input  logic                   ser_fs_i,
  output logic                   ser_d_o,
  output logic                   ser_fs_o
);
  localparam int unsigned IDX_W = (N_CH > 1) ? $clog2(N_CH) : 1;
  localparam int unsigned BIT_W = $clog2(WORD_W + 1);
  localparam int unsigned BUF_W = N_CH * WORD_W;

  cas_state_e        state_q;
  logic [BIT_W-1:0]  bit_q;
  logic [CNT_W-1:0]  slot_q;
  logic [IDX_W-1:0]  ch_q;
  logic [WORD_W-1:0] tx_sr_q;
  logic [BUF_W-1:0]  res_q;

  logic [CNT_W-1:0]  cnt_w;
  logic [N_CH-1:0]   mask_w, above_w;
  logic [WORD_W-1:0] rx_word_w, first_word_w, next_word_w;
  logic [IDX_W-1:0]  first_idx_w, next_idx_w;
  logic              first_vld_w, next_vld_w;
  logic              start_go_w, slot_end_w, chan_end_w, frame_done_w, run_w;

  assign run_w        = (state_q == ST_RUN);
  assign start_go_w   = !run_w && frame_start_i && first_vld_w;
  assign slot_end_w   = run_w && (bit_q == BIT_W'(WORD_W));
  assign chan_end_w   = slot_end_w && (slot_q == cnt_w);
  assign frame_done_w = chan_end_w && !next_vld_w;

  cas_cfg #(.CNT_W(CNT_W), .N_CH(N_CH)) i_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (cfg_we_i),
    .cnt_i  (cfg_count_i),
    .mask_i (cfg_mask_i),
    .busy_i (run_w || start_go_w),
    .done_i (frame_done_w),
    .cnt_o  (cnt_w),
    .mask_o (mask_w)
  );

  cas_rx #(.WORD_W(WORD_W)) i_rx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sdi_i  (ser_d_i),
    .sfs_i  (ser_fs_i),
    .word_o (rx_word_w)
  );

  // channels strictly above the current one
  always_comb begin
    for (int i = 0; i < N_CH; i++) begin
      above_w[i] = mask_w[i] && (i > int'(ch_q));
    end
  end

  cas_pick #(.N_CH(N_CH)) i_pick_first (
    .req_i (mask_w),
    .vld_o (first_vld_w),
    .idx_o (first_idx_w)
  );

  cas_pick #(.N_CH(N_CH)) i_pick_next (
    .req_i (above_w),
    .vld_o (next_vld_w),
    .idx_o (next_idx_w)
  );

  assign first_word_w = res_data_i[int'(first_idx_w)*WORD_W +: WORD_W];
  assign next_word_w  = res_q[int'(next_idx_w)*WORD_W +: WORD_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
      slot_q  <= '0;
      ch_q    <= '0;
      tx_sr_q <= '0;
      res_q   <= '0;
    end else if (!run_w) begin
      if (start_go_w) begin
        state_q <= ST_RUN;
        bit_q   <= '0;
        slot_q  <= '0;
        ch_q    <= first_idx_w;
        tx_sr_q <= first_word_w;
        res_q   <= res_data_i;
      end
    end else if (!slot_end_w) begin
      bit_q   <= bit_q + BIT_W'(1);
      tx_sr_q <= {tx_sr_q[WORD_W-2:0], 1'b0};
    end else begin
      bit_q <= '0;
      if (!chan_end_w) begin
        slot_q  <= slot_q + CNT_W'(1);
        tx_sr_q <= rx_word_w;
      end else if (next_vld_w) begin
        slot_q  <= '0;
        ch_q    <= next_idx_w;
        tx_sr_q <= next_word_w;
      end else begin
        state_q <= ST_IDLE;
      end
    end
  end

  assign ser_fs_o = run_w && (bit_q == '0);
  assign ser_d_o  = run_w && !slot_end_w && tx_sr_q[WORD_W-1];
endmodule

// File: rtl/cas_out_seq_chk.sv
`timescale 1ns/1ps
module cas_out_seq_chk #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned N_CH   = 6,
  parameter int unsigned CNT_W  = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             frame_start_i,
  input logic             ser_fs_o,
  input logic             busy_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic [N_CH-1:0]  mask_i,
  input logic [CNT_W-1:0] slot_i
);
  localparam int unsigned GAP_W = $clog2(WORD_W + 2) + 1;

  logic [GAP_W-1:0] since_q;
  logic             seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_q <= '0;
      seen_q  <= 1'b0;
    end else begin
      if (!busy_i)       seen_q <= 1'b0;
      else if (ser_fs_o) seen_q <= 1'b1;
      if (ser_fs_o)              since_q <= GAP_W'(1);
      else if (since_q != '1)    since_q <= since_q + GAP_W'(1);
    end
  end

  p_fs_period_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ser_fs_o && seen_q |-> since_q == GAP_W'(WORD_W + 1));

  p_first_fs_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i && frame_start_i && mask_i != '0 |=> busy_i && ser_fs_o);

  p_cfg_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && $past(busy_i) |-> $stable(cnt_i) && $stable(mask_i));

  p_empty_mask_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i && frame_start_i && mask_i == '0 |=> !busy_i && !ser_fs_o);

  p_slot_bound_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> slot_i <= cnt_i);
endmodule

bind cas_out_seq cas_out_seq_chk #(
  .WORD_W (WORD_W),
  .N_CH   (N_CH),
  .CNT_W  (CNT_W)
) i_cas_out_seq_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .frame_start_i (frame_start_i),
  .ser_fs_o      (ser_fs_o),
  .busy_i        (state_q == cas_seq_pkg::ST_RUN),
  .cnt_i         (cnt_w),
  .mask_i        (mask_w),
  .slot_i        (slot_q)
);

// File: tb/test_cas_out_seq.sv
`timescale 1ns/1ps
module test_cas_out_seq;
  localparam int NDEV = 8;
  localparam int W    = 16;
  localparam int NCH  = 6;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2.5 clk = ~clk;

  logic           cfg_we = 1'b0;
  logic [2:0]     cfg_cnt = '0;
  logic [NCH-1:0] cfg_mask = '0;
  logic           start = 1'b0;
  logic [NCH*W-1:0] res [NDEV];
  logic sd_w [0:NDEV];
  logic fs_w [0:NDEV];

  assign sd_w[NDEV] = 1'b0;
  assign fs_w[NDEV] = 1'b0;

  for (genvar p = 0; p < NDEV; p++) begin : g_dev
    cas_out_seq i_cas_out_seq (
      .clk_i         (clk),
      .rst_ni        (rst_ni),
      .cfg_we_i      (cfg_we),
      .cfg_count_i   (cfg_cnt),
      .cfg_mask_i    (cfg_mask),
      .frame_start_i (start),
      .res_data_i    (res[p]),
      .ser_d_i       (sd_w[p+1]),
      .ser_fs_i      (fs_w[p+1]),
      .ser_d_o       (sd_w[p]),
      .ser_fs_o      (fs_w[p])
    );
  end

  int tests = 0, fails = 0, cyc = 0;
  int exp_next = 0, fs_seen = 0, bits_left = 0;
  logic [W-1:0] exp_q[$];
  string        tag_q[$];
  logic [W-1:0] cur_word, cur_exp;
  string        cur_tag;
  logic [7:0]   seed;
  logic [2:0]   m_cnt;
  logic [NCH-1:0] m_mask;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [W-1:0] word_of(input int p, input int c, input logic [7:0] s);
    return {4'(p), 4'(c), s};
  endfunction

  task automatic load_res(input logic [7:0] s);
    seed = s;
    for (int p = 0; p < NDEV; p++)
      for (int c = 0; c < NCH; c++)
        res[p][c*W +: W] = word_of(p, c, s);
  endtask

  // scoreboard driver: expected host stream for the model config
  task automatic push_frame(input string tag);
    for (int c = 0; c < NCH; c++)
      if (m_mask[c])
        for (int k = 0; k <= int'(m_cnt); k++) begin
          exp_q.push_back(word_of(k, c, seed));
          tag_q.push_back(tag);
        end
  endtask

  task automatic write_cfg(input logic [2:0] c, input logic [NCH-1:0] m);
    @(negedge clk);
    cfg_we = 1'b1; cfg_cnt = c; cfg_mask = m;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic strobe(input bit first);
    @(negedge clk);
    start = 1'b1;
    if (first) exp_next = cyc + 1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input string tag, input int n);
    for (int i = 0; i < 6000; i++) begin
      if (exp_q.size() == 0 && bits_left == 0) break;
      @(negedge clk);
    end
    repeat (40) @(negedge clk);
    check(exp_q.size() == 0, tag, "words missing", exp_q.size(), 0);
    check(fs_seen == n, tag, "frame sync count", fs_seen, n);
    fs_seen = 0;
  endtask

  // monitor at the host end
  always @(negedge clk) begin
    if (rst_ni) begin
      if (bits_left > 0) begin
        cur_word = {cur_word[W-2:0], sd_w[0]};
        if (fs_w[0]) check(1'b0, "R3", "frame sync inside word", 1, 0);
        bits_left--;
        if (bits_left == 0)
          check(cur_word == cur_exp, cur_tag, "word", int'(cur_word), int'(cur_exp));
      end else if (fs_w[0]) begin
        fs_seen++;
        if (exp_q.size() == 0) begin
          check(1'b0, "R5", "unexpected frame sync", cyc, 0);
          cur_exp = 'x;
          cur_tag = "R5";
        end else begin
          cur_exp = exp_q.pop_front();
          cur_tag = tag_q.pop_front();
          check(cyc == exp_next, "R4", "frame sync cycle", cyc, exp_next);
        end
        exp_next  = cyc + W + 1;
        cur_word  = {{(W-1){1'b0}}, sd_w[0]};
        bits_left = W - 1;
      end else if (sd_w[0] !== 1'b0) begin
        check(1'b0, "R4", "data high outside word", 1, 0);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    load_res(8'h11);
    repeat (5) @(negedge clk);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    // R10: quiet outputs after reset
    check(fs_w[0] == 1'b0, "R10", "reset frame sync", int'(fs_w[0]), 0);
    check(sd_w[0] == 1'b0, "R10", "reset data", int'(sd_w[0]), 0);

    // R10 / R1: default config is one device, all six channels
    m_cnt = 3'd0; m_mask = 6'h3f;
    push_frame("R1");
    strobe(1'b1);
    wait_done("R10", 6);

    // R2: two devices, channels 0 and 1 -> interleaved order
    write_cfg(3'd1, 6'b000011); m_cnt = 3'd1; m_mask = 6'b000011;
    load_res(8'h22); push_frame("R2");
    strobe(1'b1);
    wait_done("R2", 4);

    // R6: full chain of eight, sparse mask, every upstream word relayed
    write_cfg(3'd7, 6'b100101); m_cnt = 3'd7; m_mask = 6'b100101;
    load_res(8'h33); push_frame("R6");
    strobe(1'b1);
    wait_done("R6", 24);

    // R2: four devices, single high channel
    write_cfg(3'd3, 6'b010000); m_cnt = 3'd3; m_mask = 6'b010000;
    load_res(8'h44); push_frame("R2");
    strobe(1'b1);
    wait_done("R2", 4);

    // R8: empty mask emits nothing
    write_cfg(3'd2, 6'b000000); m_cnt = 3'd2; m_mask = 6'b000000;
    strobe(1'b0);
    wait_done("R8", 0);

    // R7: write during frame is held
    write_cfg(3'd1, 6'b000110); m_cnt = 3'd1; m_mask = 6'b000110;
    load_res(8'h55); push_frame("R7");
    strobe(1'b1);
    repeat (30) @(negedge clk);
    write_cfg(3'd0, 6'b000001);
    wait_done("R7", 4);
    m_cnt = 3'd0; m_mask = 6'b000001;
    load_res(8'h66); push_frame("R7");
    strobe(1'b1);
    wait_done("R7", 1);

    // R7: write in the same clock as an accepted start is held
    load_res(8'h77); push_frame("R7");
    @(negedge clk);
    cfg_we = 1'b1; cfg_cnt = 3'd2; cfg_mask = 6'b000011;
    start = 1'b1; exp_next = cyc + 1;
    @(negedge clk);
    cfg_we = 1'b0; start = 1'b0;
    wait_done("R7", 1);
    m_cnt = 3'd2; m_mask = 6'b000011;
    load_res(8'h88); push_frame("R7");
    strobe(1'b1);
    wait_done("R7", 6);

    // R9: strobes during a running frame are ignored
    load_res(8'h99); push_frame("R9");
    strobe(1'b1);
    repeat (40) @(negedge clk);
    strobe(1'b0);
    repeat (34) @(negedge clk);
    strobe(1'b0);
    wait_done("R9", 6);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule